// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. Its clock is the high-rate input signal. A fixed divide-by-4 stage is modelled as a clock enable that fires once every four input clocks. That enable drives a dual-modulus prescaler, which counts either P+1 or P enable ticks for each of its own output ticks. A swallow counter (A, 6 bits) and a main counter (B, 13 bits) steer the prescaler. For the first A prescaler cycles of a division cycle the modulus is P+1. For the remaining B−A cycles it is P. The total ratio is therefore 4·(B·P + A) input clocks. At the end of each division cycle the block emits a one-clock pulse toward a phase detector.

The settings are valid when B is between 2 and 8191 and B is at least A. Control is a finite-state machine with three states:
- `ST_HOLD`: counters parked at their load state.
- `ST_SWALLOW`: dividing by P+1 while swallow counts remain.
- `ST_MAIN`: dividing by P.

The transitions are:
- **HOLD→SWALLOW** or **HOLD→MAIN**: on the first clock with no hold request. The target depends on whether A is zero.
- **SWALLOW→MAIN**: when the last swallow count is spent.
- **SWALLOW→SWALLOW** or **MAIN→SWALLOW**, and **SWALLOW→MAIN** or **MAIN→MAIN** at the cycle boundary: the new cycle starts in the state chosen by the freshly loaded A.
- **any→HOLD**: whenever a counter reset or power-down is requested.

Settings are sampled when leaving HOLD and at each cycle boundary.

Top module: `pswal_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0.
- R2: `psel` selects the prescaler base P: code 0 gives 8 (8/9), code 1 gives 16, code 2 gives 32 and code 3 gives 64 (64/65).
- R3: With steady settings, successive rising edges of `div_pulse` are exactly 4·(B·P + A) clock cycles apart.
- R4: `div_pulse` is high for exactly one clock cycle per division cycle.
- R5: Suppose `cnt_rst` and `pwr_dn` are first sampled low at clock edge E. Then `div_pulse` is first registered high at edge E+N−1, where N = 4·(B·P + A).
- R6: While `cnt_rst` is 1, no pulse is produced. After release, counting restarts from the load state, as in R5.
- R7: While `pwr_dn` is 1, no pulse is produced. After release, counting restarts from the load state, as in R5.
- R8: With A = 0, the period is 4·B·P.
- R9: With A = B, every prescaler cycle uses P+1, giving a period of 4·B·(P+1).
- R10: Changes to `psel`, `a_val` and `b_val` made during a division cycle do not alter that cycle. They take effect from the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter reset; holds counters in load state |
| pwr_dn | input | 1 | Power-down hold; holds counters in load state |
| psel | input | 2 | Prescaler select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B (2..8191, B ≥ A) |
| div_pulse | output | 1 | One-clock pulse per completed division cycle |

## Verification
A corrupted swallow or main count shows up as a wrong pulse spacing. The error appears in the very next division cycle and is off by a multiple of four clocks, or of 4·P clocks. A prescaler counter stuck at the wrong modulus shifts every period by a multiple of four clocks. A hold that fails to park the counters shows up as a first pulse that arrives early or late after release. A premature reload shows up as a period that mixes old and new settings. Each of these is visible within one division period.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } pswal_state_e;

endpackage

// File: rtl/pswal_quarter.sv
module pswal_quarter #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pswal_dualmod.sv
module pswal_dualmod #(
    parameter int MW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          in_tick,
    input  logic [MW-1:0] modulus,
    output logic          out_tick
);
    logic [MW-1:0] cnt;

    assign out_tick = in_tick && (cnt == modulus - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= '0;
        end else if (in_tick) begin
            if (out_tick) cnt <= '0;
            else          cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pswal_ctrl.sv
module pswal_ctrl
    import pswal_pkg::*;
#(
    parameter int A_W   = 6,
    parameter int B_W   = 13,
    parameter int SEL_W = 2,
    parameter int P_MIN = 8,
    parameter int MW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             pre_tick,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [MW-1:0]    modulus,
    output logic             pulse
);
    pswal_state_e     state, nxt;
    logic [A_W-1:0]   a_left;
    logic [B_W-1:0]   b_left;
    logic [SEL_W-1:0] sel_r;
    logic             boundary;
    logic             b_last;

    assign b_last  = (b_left == B_W'(1));
    assign modulus = MW'(P_MIN << sel_r) + MW'(state == ST_SWALLOW);

    always_comb begin
        nxt      = state;
        boundary = 1'b0;
        unique case (state)
            ST_HOLD: begin
                nxt = (a_in != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (pre_tick) begin
                    if (b_last) begin
                        boundary = 1'b1;
                        nxt      = (a_in != '0) ? ST_SWALLOW : ST_MAIN;
                    end else if (a_left == A_W'(1)) begin
                        nxt = ST_MAIN;
                    end
                end
            end
            ST_MAIN: begin
                if (pre_tick && b_last) begin
                    boundary = 1'b1;
                    nxt      = (a_in != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: nxt = ST_HOLD;
        endcase
        if (hold) begin
            nxt      = ST_HOLD;
            boundary = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HOLD;
            a_left <= '0;
            b_left <= '0;
            sel_r  <= '0;
        end else begin
            state <= nxt;
            if (hold) begin
                a_left <= a_in;
                b_left <= b_in;
                sel_r  <= sel_in;
            end else if (state == ST_HOLD || boundary) begin
                a_left <= a_in;
                b_left <= b_in;
                sel_r  <= sel_in;
            end else if (pre_tick) begin
                b_left <= b_left - 1'b1;
                if (state == ST_SWALLOW) a_left <= a_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= boundary;
    end
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
    import pswal_pkg::*;
#(
    parameter int FIX_DIV = 4,
    parameter int A_W     = 6,
    parameter int B_W     = 13,
    parameter int SEL_W   = 2,
    parameter int P_MIN   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_rst,
    input  logic             pwr_dn,
    input  logic [SEL_W-1:0] psel,
    input  logic [A_W-1:0]   a_val,
    input  logic [B_W-1:0]   b_val,
    output logic             div_pulse
);
    localparam int P_MAX = P_MIN << ((1 << SEL_W) - 1);
    localparam int MW    = $clog2(P_MAX + 2);

    logic          hold;
    logic          quarter_tick;
    logic          pre_tick;
    logic [MW-1:0] modulus;

    assign hold = cnt_rst | pwr_dn;

    pswal_quarter #(.DIV(FIX_DIV)) u_quarter (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .tick  (quarter_tick)
    );

    pswal_dualmod #(.MW(MW)) u_dualmod (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .in_tick  (quarter_tick),
        .modulus  (modulus),
        .out_tick (pre_tick)
    );

    pswal_ctrl #(
        .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .P_MIN(P_MIN), .MW(MW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .pre_tick (pre_tick),
        .sel_in   (psel),
        .a_in     (a_val),
        .b_in     (b_val),
        .modulus  (modulus),
        .pulse    (div_pulse)
    );
endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_rst,
    input logic pwr_dn,
    input logic div_pulse,
    input logic quarter_tick,
    input logic pre_tick
);
    // R1
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            reset_quiet_chk: assert (div_pulse == 1'b0);
        end
    end

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R6
    cnt_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !div_pulse);

    // R7
    pwr_dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !div_pulse);

    // R3
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(pre_tick && quarter_tick));
endmodule

bind pswal_divider pswal_divider_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_rst      (cnt_rst),
    .pwr_dn       (pwr_dn),
    .div_pulse    (div_pulse),
    .quarter_tick (quarter_tick),
    .pre_tick     (pre_tick)
);

// File: tb/pswal_divider_bench.sv
module pswal_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_rst;
    logic        pwr_dn;
    logic [1:0]  psel;
    logic [5:0]  a_val;
    logic [12:0] b_val;
    logic        div_pulse;

    int total = 0;
    int bad   = 0;
    int cnt;
    int seen;

    always #4 clk = ~clk;

    pswal_divider u_pswal_divider (
        .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
        .psel(psel), .a_val(a_val), .b_val(b_val), .div_pulse(div_pulse)
    );

    function automatic int exp_n(input int ps, input int a, input int b);
        return 4 * (b * (8 << ps) + a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (div_pulse) break;
            if (n > 40000) break;
        end
    endtask

    task automatic set_cfg(input int ps, input int a, input int b);
        psel  = 2'(ps);
        a_val = 6'(a);
        b_val = 13'(b);
    endtask

    task automatic measure(input int ps, input int a, input int b, input string tag);
        int n;
        int e;
        e = exp_n(ps, a, b);
        @(negedge clk);
        cnt_rst = 1'b1;
        set_cfg(ps, a, b);
        @(negedge clk);
        cnt_rst = 1'b0;
        wait_pulse(n);
        check(n == e, {tag, " R5 first pulse"}, n, e);
        @(negedge clk);
        check(div_pulse == 1'b0, {tag, " R4 width"}, int'(div_pulse), 0);
        wait_pulse(n);
        check(n + 1 == e, {tag, " R3 period"}, n + 1, e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        rst_n = 1'b0; cnt_rst = 1'b0; pwr_dn = 1'b0;
        set_cfg(0, 1, 3);
        repeat (6) begin
            @(negedge clk);
            check(div_pulse == 1'b0, "R1 reset", int'(div_pulse), 0);
        end
        rst_n = 1'b1;

        // R2: one directed case per prescaler code
        measure(0, 3, 4, "R2 p8");
        measure(1, 2, 5, "R2 p16");
        measure(2, 1, 3, "R2 p32");
        measure(3, 0, 2, "R2 p64");
        // R8: no swallow
        measure(0, 0, 2, "R8 a0");
        // R9: all swallow
        measure(1, 5, 5, "R9 a_eq_b");
        measure(3, 63, 63, "R9 a63");

        // R3 random settings
        for (int i = 0; i < 16; i++) begin
            int ps, a, b;
            ps = int'($urandom % 4);
            b  = 2 + int'($urandom % 5);
            a  = int'($urandom % (b + 1));
            measure(ps, a, b, "R3 rand");
        end

        // R10: change mid-cycle takes effect one boundary later
        measure(0, 1, 3, "R10 base");
        wait_pulse(cnt);
        set_cfg(1, 0, 2);
        wait_pulse(cnt);
        check(cnt == exp_n(0, 1, 3), "R10 old kept", cnt, exp_n(0, 1, 3));
        wait_pulse(cnt);
        check(cnt == exp_n(1, 0, 2), "R10 new applied", cnt, exp_n(1, 0, 2));

        // R6: counter reset hold
        set_cfg(0, 1, 3);
        wait_pulse(cnt);
        repeat (37) @(negedge clk);
        cnt_rst = 1'b1;
        seen = 0;
        repeat (2000) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        check(seen == 0, "R6 no pulses held", seen, 0);
        cnt_rst = 1'b0;
        wait_pulse(cnt);
        check(cnt == exp_n(0, 1, 3), "R6 restart", cnt, exp_n(0, 1, 3));

        // R7: power-down hold
        set_cfg(2, 2, 2);
        repeat (53) @(negedge clk);
        pwr_dn = 1'b1;
        seen = 0;
        repeat (2000) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        check(seen == 0, "R7 no pulses held", seen, 0);
        pwr_dn = 1'b0;
        wait_pulse(cnt);
        check(cnt == exp_n(2, 2, 2), "R7 restart", cnt, exp_n(2, 2, 2));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule